// File: doc/BRIEF.md
# Dirty Line Tracker with Update Scheduling

This block holds one dirty flag for every display line of a compressed frame buffer. Pixel writes mark lines dirty. The scanout logic asks about each line as it reaches it, and the block answers two things. First, whether the line must be refreshed (fetched uncompressed and compressed again) in this frame. Second, whether the uncompressed copy has to be fetched at all. A flag is cleared once its line has been refreshed.

Normally a write marks only the line named by its Y index. For linear buffers whose line pitch is irregular (neither 1024 nor 2048 bytes), the whole-frame mode is used instead: any pixel write marks every line dirty. A second option inserts a static frame between update frames. In a static frame, dirty lines are not refreshed and keep their flags. A line whose compression failed is still fetched from the uncompressed buffer in either kind of frame.

Top module: `dirty_line_tracker`

## Requirements
- R1: Reset sets every dirty flag and makes the current frame an update frame (`upd_frame`=1, `rsp_valid`=0). The first frame after reset therefore refreshes every line.
- R2: With `frame_all_en`=0, a write with `wr_valid`=1 sets the flag of line `wr_line` only. The flags of all other lines are unchanged.
- R3: With `frame_all_en`=1, a write with `wr_valid`=1 sets the flags of all lines, whatever `wr_line` is.
- R4: A query answers from the flag as it was before that cycle's writes and clears. In an update frame, `rsp_refresh`=1 exactly when the queried line is dirty.
- R5: A query that yields `rsp_refresh`=1 clears that line's flag. A flag is cleared only in this way.
- R6: In a static frame (`upd_frame`=0), `rsp_refresh` is 0 and the queried line's flag is kept.
- R7: On `sof`, the next frame is the opposite kind of frame when `static_insert_en`=1, and an update frame when it is 0. Without `sof`, `upd_frame` holds its value.
- R8: A write that sets a line in the same cycle as a query clears it leaves the flag set.
- R9: `rsp_raw`=1 when the query had `qry_comp_fail`=1 or when `rsp_refresh`=1. Otherwise `rsp_raw`=0.
- R10: `rsp_valid` is 1 in exactly the cycle after a cycle with `qry_valid`=1. The response fields belong to that query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Pixel write strobe |
| wr_line | input | LW | Y line index of the write |
| frame_all_en | input | 1 | Whole-frame dirty mode |
| static_insert_en | input | 1 | Insert a static frame between update frames |
| sof | input | 1 | Start-of-frame pulse |
| qry_valid | input | 1 | Line query strobe from scanout |
| qry_line | input | LW | Queried line |
| qry_comp_fail | input | 1 | Compression of the queried line failed |
| upd_frame | output | 1 | Current frame is an update frame |
| rsp_valid | output | 1 | Query response valid |
| rsp_refresh | output | 1 | Refresh the queried line this frame |
| rsp_raw | output | 1 | Fetch the queried line uncompressed |

## Verification
The bench builds the block with LINES=8, so that LW=3. At that size, it can sweep every line after reset and after a whole-frame write, and confirm that no line was missed. A single write can also be shown to touch one line and leave every other line clean. The small depth leaves cycles free for long runs of frame boundaries with insertion switched on and off. It also leaves room to place a write on exactly the cycle of a clearing query.

// File: rtl/dirty_line_tracker.sv
module dirty_line_tracker #(
  parameter int LINES = 64,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [LW-1:0] wr_line,
  input  logic          frame_all_en,
  input  logic          static_insert_en,
  input  logic          sof,
  input  logic          qry_valid,
  input  logic [LW-1:0] qry_line,
  input  logic          qry_comp_fail,
  output logic          upd_frame,
  output logic          rsp_valid,
  output logic          rsp_refresh,
  output logic          rsp_raw
);

  logic [LINES-1:0] dirty;
  logic [LINES-1:0] set_mask;
  logic [LINES-1:0] clr_mask;
  logic             refresh_now;

  assign refresh_now = qry_valid & upd_frame & dirty[qry_line];

  assign set_mask = !wr_valid     ? '0 :
                    frame_all_en  ? '1 :
                                    (LINES'(1) << wr_line);

  assign clr_mask = refresh_now ? (LINES'(1) << qry_line) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirty <= '1;
    end else begin
      dirty <= (dirty & ~clr_mask) | set_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_frame <= 1'b1;
    end else if (sof) begin
      upd_frame <= static_insert_en ? ~upd_frame : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_refresh <= 1'b0;
      rsp_raw     <= 1'b0;
    end else begin
      rsp_valid   <= qry_valid;
      rsp_refresh <= refresh_now;
      rsp_raw     <= qry_valid & (refresh_now | qry_comp_fail);
    end
  end

endmodule

// File: rtl/dirty_line_tracker_chk.sv
module dirty_line_tracker_chk (
  input logic clk,
  input logic rst_n,
  input logic sof,
  input logic static_insert_en,
  input logic qry_valid,
  input logic qry_comp_fail,
  input logic upd_frame,
  input logic rsp_valid,
  input logic rsp_refresh,
  input logic rsp_raw
);

  // R10
  rsp_follows_qry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> rsp_valid);

  // R10
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |=> !rsp_valid);

  // R6
  static_no_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && !upd_frame) |=> !rsp_refresh);

  // R9
  fail_forces_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid && qry_comp_fail) |=> rsp_raw);

  // R7
  insert_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && static_insert_en) |=> (upd_frame != $past(upd_frame)));

  // R7
  no_insert_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && !static_insert_en) |=> upd_frame);

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sof |=> $stable(upd_frame));

endmodule

bind dirty_line_tracker dirty_line_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .static_insert_en(static_insert_en),
  .qry_valid(qry_valid), .qry_comp_fail(qry_comp_fail), .upd_frame(upd_frame),
  .rsp_valid(rsp_valid), .rsp_refresh(rsp_refresh), .rsp_raw(rsp_raw)
);

// File: tb/test_dirty_line_tracker.sv
module test_dirty_line_tracker;
  localparam int LINES = 8;
  localparam int LW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, frame_all_en = 0, static_insert_en = 0, sof = 0;
  logic qry_valid = 0, qry_comp_fail = 0;
  logic [LW-1:0] wr_line = 0, qry_line = 0;
  logic upd_frame, rsp_valid, rsp_refresh, rsp_raw;

  always #10 clk = ~clk;

  dirty_line_tracker #(.LINES(LINES)) i_dirty_line_tracker (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_line(wr_line),
    .frame_all_en(frame_all_en), .static_insert_en(static_insert_en), .sof(sof),
    .qry_valid(qry_valid), .qry_line(qry_line), .qry_comp_fail(qry_comp_fail),
    .upd_frame(upd_frame), .rsp_valid(rsp_valid), .rsp_refresh(rsp_refresh),
    .rsp_raw(rsp_raw));

  typedef struct {
    bit    upd;
    bit    has_rsp;
    bit    refresh;
    bit    raw;
    string tag;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit m_dirty[LINES];
  bit m_upd;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit wv, int wl, bit fa, bit si, bit sf,
                     bit qv, int ql, bit cf, string tag);
    item_t it;
    bit ref_now;
    @(negedge clk);
    wr_valid = wv; wr_line = LW'(wl); frame_all_en = fa;
    static_insert_en = si; sof = sf;
    qry_valid = qv; qry_line = LW'(ql); qry_comp_fail = cf;
    ref_now = qv && m_upd && m_dirty[ql];
    if (ref_now) m_dirty[ql] = 0;
    if (wv) begin
      if (fa) foreach (m_dirty[i]) m_dirty[i] = 1;
      else m_dirty[wl] = 1;
    end
    if (sf) m_upd = si ? !m_upd : 1'b1;
    it.upd = m_upd; it.has_rsp = qv; it.refresh = ref_now;
    it.raw = qv && (ref_now || cf); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic ask(int l, bit cf, string tag);
    cyc(0, 0, 0, 0, 0, 1, l, cf, tag);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(upd_frame == it.upd, "R7", "upd_frame", upd_frame, it.upd);
      chk(rsp_valid == it.has_rsp, "R10", "rsp_valid", rsp_valid, it.has_rsp);
      if (it.has_rsp) begin
        chk(rsp_refresh == it.refresh, it.tag, "rsp_refresh", rsp_refresh, it.refresh);
        chk(rsp_raw == it.raw, it.tag, "rsp_raw", rsp_raw, it.raw);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (m_dirty[i]) m_dirty[i] = 1;
    m_upd = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(upd_frame == 1, "R1", "upd_frame after reset", upd_frame, 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    // R1 R4 R5: full first update, each clears
    for (int l = 0; l < LINES; l++) ask(l, 0, "R1");
    for (int l = 0; l < LINES; l++) ask(l, 0, "R5");
    // R2: single line write
    cyc(1, 5, 0, 0, 0, 0, 0, 0, "R2");
    for (int l = 0; l < LINES; l++) ask(l, 0, "R2");
    // R9: compression fail on clean line
    ask(4, 1, "R9");
    // R4: query sees pre-write state
    cyc(1, 2, 0, 0, 0, 1, 2, 0, "R4");
    ask(2, 0, "R4");
    // R8: write and clear same cycle
    cyc(1, 6, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 6, 0, 0, 0, 1, 6, 0, "R8");
    ask(6, 0, "R8");
    ask(6, 0, "R5");
    // R3: whole-frame write
    cyc(1, 1, 1, 0, 0, 0, 0, 0, "R3");
    for (int l = 0; l < LINES; l++) ask(l, 0, "R3");
    // R6 R7 R9: static frames
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 1, 0, 0, 0, 0, "R6");
    ask(1, 0, "R6");
    ask(1, 1, "R9");
    ask(3, 0, "R6");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    ask(1, 0, "R6");
    ask(1, 0, "R5");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 1, 1, 0, 1, "R9");
    cyc(0, 0, 0, 1, 1, 0, 0, 0, "R7");
    idle();
    idle();
    @(negedge clk);
    chk(q.size() == 0, "R10", "pending items", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule